// File: doc/BRIEF.md
# Video stream frame-marker converter

This block sits in a pixel stream that uses ready/valid handshaking and rewrites the two side-band marker bits from one framing convention into the other. In the start-of-frame convention, the user bit flags the first pixel of a frame and the last bit flags the final pixel of every line. In the end-of-frame convention, the user bit flags the final pixel of every line and the last bit is raised only on the final pixel of the whole frame. A parameter selects which convention comes in and which goes out. Pixel data passes through unchanged and in order.

The block does not forward the markers it receives. It follows the pixel position with a column counter and a row counter, sized by the frame width and height inputs, and builds the outgoing markers from that position. The incoming frame marker (start-of-frame in one direction, end-of-frame in the other) realigns the counters whenever it arrives, even in the middle of a frame. A stream that was cut short, or a reset that lands mid-frame, is therefore absorbed at the next frame boundary. When the block converts towards the start-of-frame convention, it does not know where a frame begins until it has seen one frame end. Until then it withholds the start-of-frame flag.

The output is registered and has a one-entry skid register, so the input ready is also a register output.

Top module: `vid_mark_conv`

## Requirements
- R1: With DIR = CONV_A_TO_B (start-of-frame in, end-of-frame out), m_user is high exactly on beats at column width-1, and m_last is high exactly on the beat at column width-1 of row height-1. Columns and rows count from 0 at the top-left pixel.
- R2: With DIR = CONV_B_TO_A (end-of-frame in, start-of-frame out), m_last is high exactly on beats at column width-1. Once the height is known, m_user is high exactly on the beat at column 0, row 0.
- R3: After reset in CONV_B_TO_A, m_user stays low until the height is known. The height becomes known when the row counter wraps after a complete frame, or when an input beat carries s_last.
- R4: The column advances on every accepted input beat and wraps to 0 after width-1. The row advances on each column wrap and wraps to 0 after height-1. In CONV_A_TO_B, an accepted beat with s_user high is treated as column 0, row 0, wherever the counters stood.
- R5: In CONV_B_TO_A, an accepted beat with s_last high ends the frame: the next accepted beat is column 0, row 0, and the height becomes known.
- R6: The unused incoming marker (s_last in CONV_A_TO_B, s_user in CONV_B_TO_A) has no effect on any output.
- R7: A synchronous reset (rst high) clears m_valid, returns the position to column 0, row 0 and clears the height-known state. frame_w and frame_h may change only while reset is held. Any size from 3 by 3 upward is supported.
- R8: Every accepted input pixel appears on m_data exactly once, in order, with no extra beats.
- R9: While m_valid is high and m_ready is low, m_valid stays high and m_data, m_last and m_user hold their values.
- R10: s_ready is high after reset. It falls only in the cycle after a beat was accepted while the output was stalled, so at most two beats are held inside the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_w | input | DIM_W | Frame width in pixels (at least 3) |
| frame_h | input | DIM_W | Frame height in lines (at least 3) |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_data | input | PIX_W | Input pixel |
| s_last | input | 1 | Input last marker |
| s_user | input | 1 | Input user marker |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | PIX_W | Output pixel |
| m_last | output | 1 | Regenerated last marker |
| m_user | output | 1 | Regenerated user marker |

## Verification
The bench builds the block twice with PIX_W = 8 and DIM_W = 4 and chains the two: a CONV_A_TO_B instance feeds a CONV_B_TO_A instance. Both the converted stream in the middle and the restored stream at the end are checked. The narrow dimension width keeps frames small (5 by 4, 3 by 3, 4 by 3), so many frame wraps, the minimum size, and the first-frame period before the height is known all occur within a short run. For one phase the second instance is fed directly by the bench, which lets it inject an early end-of-frame marker that the first instance would never produce.

// File: rtl/vid_mark_pkg.sv
package vid_mark_pkg;

  // Direction of conversion: which marker convention enters the block.
  typedef enum logic {
    CONV_A_TO_B = 1'b0,  // user = frame start, last = line end  ->  last = frame end, user = line end
    CONV_B_TO_A = 1'b1   // the reverse
  } conv_dir_e;

endpackage

// File: rtl/vid_pos_track.sv
module vid_pos_track #(
  parameter int DIM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             sof_hit,
  input  logic             eof_hit,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  output logic [DIM_W-1:0] pos_x,
  output logic [DIM_W-1:0] pos_y,
  output logic [DIM_W-1:0] eff_x,
  output logic [DIM_W-1:0] eff_y,
  output logic             known
);

  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  // A start-of-frame marker overrides the stored position for this beat.
  always_comb begin
    eff_x = sof_hit ? '0 : pos_x;
    eff_y = sof_hit ? '0 : pos_y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_x <= '0;
      pos_y <= '0;
      known <= 1'b0;
    end else if (adv) begin
      if (eof_hit) begin
        pos_x <= '0;
        pos_y <= '0;
        known <= 1'b1;
      end else if (eff_x + ONE == width) begin
        pos_x <= '0;
        if (eff_y + ONE == height) begin
          pos_y <= '0;
          known <= 1'b1;
        end else begin
          pos_y <= eff_y + ONE;
        end
      end else begin
        pos_x <= eff_x + ONE;
        pos_y <= eff_y;
      end
    end
  end

endmodule

// File: rtl/vid_mark_gen.sv
module vid_mark_gen
  import vid_mark_pkg::*;
#(
  parameter int        DIM_W = 10,
  parameter conv_dir_e DIR   = CONV_A_TO_B
) (
  input  logic [DIM_W-1:0] x,
  input  logic [DIM_W-1:0] y,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic             known,
  output logic             mark_last,
  output logic             mark_user
);

  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  logic line_end, bottom_row, top_left;

  always_comb begin
    line_end   = (x == width - ONE);
    bottom_row = (y == height - ONE);
    top_left   = (x == '0) && (y == '0);
  end

  generate
    if (DIR == CONV_A_TO_B) begin : g_to_eof
      assign mark_last = line_end && bottom_row;
      assign mark_user = line_end;
    end else begin : g_to_sof
      assign mark_last = line_end;
      assign mark_user = top_left && known;
    end
  endgenerate

endmodule

// File: rtl/vid_skid_out.sv
module vid_skid_out #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_beat,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_beat
);

  logic         skid_full;
  logic [W-1:0] skid_q;
  logic         take, load;

  assign in_ready = !skid_full;
  assign take     = in_valid && !skid_full;
  assign load     = out_ready || !out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      skid_full <= 1'b0;
    end else if (load) begin
      if (skid_full) begin
        out_valid <= 1'b1;
        skid_full <= 1'b0;
      end else begin
        out_valid <= take;
      end
    end else if (take) begin
      skid_full <= 1'b1;
    end
  end

  // Data path without reset so it maps onto plain registers.
  always_ff @(posedge clk) begin
    if (load) begin
      out_beat <= skid_full ? skid_q : in_beat;
    end
    if (!load && take) begin
      skid_q <= in_beat;
    end
  end

endmodule

// File: rtl/vid_mark_conv.sv
module vid_mark_conv
  import vid_mark_pkg::*;
#(
  parameter int        PIX_W = 24,
  parameter int        DIM_W = 10,
  parameter conv_dir_e DIR   = CONV_A_TO_B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIM_W-1:0] frame_w,
  input  logic [DIM_W-1:0] frame_h,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_data,
  input  logic             s_last,
  input  logic             s_user,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_data,
  output logic             m_last,
  output logic             m_user
);

  localparam int BEAT_W = PIX_W + 2;

  logic             accept;
  logic             sof_hit, eof_hit;
  logic [DIM_W-1:0] pos_x, pos_y, eff_x, eff_y;
  logic             known;
  logic             mark_last, mark_user;
  logic [BEAT_W-1:0] out_beat;

  assign accept = s_valid && s_ready;

  generate
    if (DIR == CONV_A_TO_B) begin : g_sync_sof
      assign sof_hit = s_user;
      assign eof_hit = 1'b0;
    end else begin : g_sync_eof
      assign sof_hit = 1'b0;
      assign eof_hit = s_last;
    end
  endgenerate

  vid_pos_track #(.DIM_W(DIM_W)) u_pos (
    .clk     (clk),
    .rst     (rst),
    .adv     (accept),
    .sof_hit (sof_hit),
    .eof_hit (eof_hit),
    .width   (frame_w),
    .height  (frame_h),
    .pos_x   (pos_x),
    .pos_y   (pos_y),
    .eff_x   (eff_x),
    .eff_y   (eff_y),
    .known   (known)
  );

  vid_mark_gen #(.DIM_W(DIM_W), .DIR(DIR)) u_mark (
    .x         (eff_x),
    .y         (eff_y),
    .width     (frame_w),
    .height    (frame_h),
    .known     (known),
    .mark_last (mark_last),
    .mark_user (mark_user)
  );

  vid_skid_out #(.W(BEAT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_beat   ({s_data, mark_last, mark_user}),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_beat  (out_beat)
  );

  assign {m_data, m_last, m_user} = out_beat;

endmodule

// File: rtl/vid_mark_conv_chk.sv
module vid_mark_conv_chk
  import vid_mark_pkg::*;
#(
  parameter int        PIX_W = 24,
  parameter int        DIM_W = 10,
  parameter conv_dir_e DIR   = CONV_A_TO_B
) (
  input logic             clk,
  input logic             rst,
  input logic [DIM_W-1:0] frame_w,
  input logic [DIM_W-1:0] frame_h,
  input logic             s_valid,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [PIX_W-1:0] m_data,
  input logic             m_last,
  input logic             m_user,
  input logic [DIM_W-1:0] pos_x,
  input logic [DIM_W-1:0] pos_y
);

  p_rst_idle_r7: assert property (@(posedge clk) rst |=> !m_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last) && $stable(m_user)));

  p_ready_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(s_ready) |-> $past(s_valid && m_valid && !m_ready));

  p_pos_range_r4: assert property (@(posedge clk) disable iff (rst)
    (pos_x < frame_w) && (pos_y < frame_h));

  generate
    if (DIR == CONV_A_TO_B) begin : g_a2b
      // R1: a frame end is always also a line end
      p_eof_on_eol_r1: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_last) |-> m_user);
    end else begin : g_b2a
      // R2: a frame start (column 0) is never a line end when width >= 3
      p_sof_not_eol_r2: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_user) |-> !m_last);
    end
  endgenerate

endmodule

bind vid_mark_conv vid_mark_conv_chk #(.PIX_W(PIX_W), .DIM_W(DIM_W), .DIR(DIR)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .frame_w (frame_w),
  .frame_h (frame_h),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .m_last  (m_last),
  .m_user  (m_user),
  .pos_x   (pos_x),
  .pos_y   (pos_y)
);

// File: tb/vid_mark_conv_bench.sv
module vid_mark_conv_bench;
  import vid_mark_pkg::*;

  localparam int PW = 8;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [DW-1:0] frame_w, frame_h;

  // source A (start-of-frame convention) into the first instance
  logic          a_valid = 1'b0, a_last = 1'b0, a_user = 1'b0;
  logic [PW-1:0] a_data = '0;
  logic          u1_ready;
  // link between instances
  logic          l_valid, l_last, l_user, l_ready;
  logic [PW-1:0] l_data;
  // direct source B (end-of-frame convention) into the second instance
  logic          b_valid = 1'b0, b_last = 1'b0, b_user = 1'b0;
  logic [PW-1:0] b_data = '0;
  logic          sel = 1'b0;
  logic          u2_valid, u2_last, u2_user, u2_ready;
  logic [PW-1:0] u2_data;
  // final output
  logic          o_valid, o_last, o_user;
  logic          o_ready = 1'b0;
  logic [PW-1:0] o_data;

  assign l_ready  = sel ? 1'b0 : u2_ready;
  assign u2_valid = sel ? b_valid : l_valid;
  assign u2_data  = sel ? b_data  : l_data;
  assign u2_last  = sel ? b_last  : l_last;
  assign u2_user  = sel ? b_user  : l_user;

  vid_mark_conv #(.PIX_W(PW), .DIM_W(DW), .DIR(CONV_A_TO_B)) u_vid_mark_conv (
    .clk(clk), .rst(rst), .frame_w(frame_w), .frame_h(frame_h),
    .s_valid(a_valid), .s_ready(u1_ready), .s_data(a_data), .s_last(a_last), .s_user(a_user),
    .m_valid(l_valid), .m_ready(l_ready), .m_data(l_data), .m_last(l_last), .m_user(l_user));

  vid_mark_conv #(.PIX_W(PW), .DIM_W(DW), .DIR(CONV_B_TO_A)) u_vid_mark_conv_back (
    .clk(clk), .rst(rst), .frame_w(frame_w), .frame_h(frame_h),
    .s_valid(u2_valid), .s_ready(u2_ready), .s_data(u2_data), .s_last(u2_last), .s_user(u2_user),
    .m_valid(o_valid), .m_ready(o_ready), .m_data(o_data), .m_last(o_last), .m_user(o_user));

  int checks = 0;
  int errors = 0;
  int W = 5, H = 4;
  int pv = 70, pr = 70;
  bit src_on = 1'b0;
  bit force_a = 1'b0, force_b = 1'b0;
  bit a_fired = 1'b0, b_fired = 1'b0;
  int sx, sy, bx, by;            // source generators
  int m1x, m1y;                  // expected position, first instance
  int m2x, m2y; bit m2k;         // expected position and height-known, second instance
  logic [PW+1:0] q1[$], q2[$];
  string         q1t[$], q2t[$];
  bit            held = 1'b0;
  logic [PW+1:0] held_beat;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected outcome of a beat entering the first instance (R1, R4, R6).
  task automatic model1(input logic [PW-1:0] d, input logic u);
    string t;
    t = "R1/R6";
    if (u) begin
      if (m1x != 0 || m1y != 0) t = "R4";
      m1x = 0; m1y = 0;
    end
    q1.push_back({d, 1'(m1x == W-1 && m1y == H-1), 1'(m1x == W-1)});
    q1t.push_back(t);
    if (m1x == W-1) begin
      m1x = 0;
      m1y = (m1y == H-1) ? 0 : m1y + 1;
    end else m1x++;
  endtask

  // Expected outcome of a beat entering the second instance (R2, R3, R5, R6).
  task automatic model2(input logic [PW-1:0] d, input logic l, input bit after_early);
    string t;
    t = after_early ? "R5" : (m2k ? "R2/R6" : "R3");
    q2.push_back({d, 1'(m2x == W-1), 1'(m2k && m2x == 0 && m2y == 0)});
    q2t.push_back(t);
    if (l) begin
      m2x = 0; m2y = 0; m2k = 1'b1;
    end else if (m2x == W-1) begin
      m2x = 0;
      if (m2y == H-1) begin m2y = 0; m2k = 1'b1; end
      else m2y++;
    end else m2x++;
  endtask

  bit early_pending = 1'b0;

  task automatic step();
    @(negedge clk);
    if (a_fired) a_valid = 1'b0;
    if (b_fired) b_valid = 1'b0;
    a_fired = 1'b0; b_fired = 1'b0;
    if (!a_valid && src_on && !sel && ($urandom % 100) < pv) begin
      if (force_a) begin sx = 0; sy = 0; force_a = 1'b0; end
      a_valid = 1'b1;
      a_data  = PW'($urandom);
      a_user  = (sx == 0 && sy == 0);
      a_last  = 1'($urandom);
      if (sx == W-1) begin sx = 0; sy = (sy == H-1) ? 0 : sy + 1; end
      else sx++;
    end
    if (!b_valid && src_on && sel && ($urandom % 100) < pv) begin
      b_valid = 1'b1;
      b_data  = PW'($urandom);
      b_user  = 1'($urandom);
      if (force_b) begin
        b_last = 1'b1; bx = 0; by = 0; force_b = 1'b0;
      end else begin
        b_last = (bx == W-1 && by == H-1);
        if (bx == W-1) begin bx = 0; by = (by == H-1) ? 0 : by + 1; end
        else bx++;
      end
    end
    o_ready = (($urandom % 100) < pr);
    #1;
    if (held) begin  // R9
      chk("R9 valid held", int'(o_valid), 1);
      chk("R9 beat stable", int'({o_data, o_last, o_user}), int'(held_beat));
    end
    held = o_valid && !o_ready;
    held_beat = {o_data, o_last, o_user};
    if (a_valid && u1_ready) begin
      a_fired = 1'b1;
      model1(a_data, a_user);
    end
    if (!sel && l_valid && u2_ready) begin
      if (q1.size() == 0) chk("R8 unexpected link beat", 1, 0);
      else begin
        logic [PW+1:0] e; string t;
        e = q1.pop_front(); t = q1t.pop_front();
        chk("R8 link data", int'(l_data), int'(e[PW+1:2]));
        chk({t, " link last"}, int'(l_last), int'(e[1]));
        chk({t, " link user"}, int'(l_user), int'(e[0]));
      end
      model2(l_data, l_last, 1'b0);
    end
    if (sel && b_valid && u2_ready) begin
      b_fired = 1'b1;
      model2(b_data, b_last, early_pending);
      early_pending = b_last && (bx == 0 && by == 0) && 1'b0;
    end
    if (o_valid && o_ready) begin
      if (q2.size() == 0) chk("R8 unexpected output beat", 1, 0);
      else begin
        logic [PW+1:0] e; string t;
        e = q2.pop_front(); t = q2t.pop_front();
        chk("R8 out data", int'(o_data), int'(e[PW+1:2]));
        chk({t, " out last"}, int'(o_last), int'(e[1]));
        chk({t, " out user"}, int'(o_user), int'(e[0]));
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // R7: reset, optionally with a new frame size, then check idle state
  task automatic do_reset(input int nw, input int nh);
    @(negedge clk);
    rst = 1'b1;
    a_valid = 1'b0; b_valid = 1'b0; a_fired = 1'b0; b_fired = 1'b0;
    held = 1'b0;
    W = nw; H = nh;
    frame_w = DW'(nw); frame_h = DW'(nh);
    sx = 0; sy = 0; bx = 0; by = 0;
    m1x = 0; m1y = 0; m2x = 0; m2y = 0; m2k = 1'b0;
    q1.delete(); q1t.delete(); q2.delete(); q2t.delete();
    repeat (3) @(negedge clk);
    #1;
    chk("R7 reset m_valid first", int'(l_valid), 0);
    chk("R7 reset m_valid second", int'(o_valid), 0);
    chk("R10 reset s_ready first", int'(u1_ready), 1);
    chk("R10 reset s_ready second", int'(u2_ready), 1);
    rst = 1'b0;
  endtask

  initial begin
    frame_w = DW'(W); frame_h = DW'(H);
    void'($urandom(32'd20240517));
    do_reset(5, 4);
    src_on = 1'b1;
    // main traffic, start-of-frame source through both instances
    pv = 70; pr = 70; run(400);
    // full output stall: skid fills, ready falls (R10)
    pv = 100; pr = 0; run(12);
    #2;
    chk("R10 s_ready low when both stages full", int'(u2_ready), 0);
    pr = 100; run(30);
    // unexpected start-of-frame in the middle of a line (R4)
    pv = 80; pr = 80; run(7);
    force_a = 1'b1; run(60);
    force_a = 1'b1; run(150);
    // reset in mid-frame with the minimum frame size (R7)
    pv = 90; pr = 60; run(13);
    do_reset(3, 3);
    run(300);
    // drive the second instance directly with end-of-frame markers
    src_on = 1'b0; pr = 100; run(20);
    sel = 1'b1;
    do_reset(4, 3);
    src_on = 1'b1; pv = 75; pr = 75;
    run(90);
    // early end-of-frame: next beat must be top-left (R5)
    while (!(bx == 2 && by == 1)) step();
    force_b = 1'b1; step();
    while (force_b || b_valid) step();
    early_pending = 1'b1;
    while (early_pending) begin
      step();
      if (b_fired) early_pending = 1'b0;
    end
    run(120);
    // drain: nothing missing (R8)
    src_on = 1'b0; pr = 100; run(30);
    chk("R8 link queue empty", q1.size(), 0);
    chk("R8 output queue empty", q2.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule